// File: doc/BRIEF.md
# Scalar Integer ALU with Condition Flag

This block is a one-operation-per-cycle scalar integer unit for a GPU-style shader core. Each accepted operation carries an opcode and two 64-bit source operands. The 32-bit operations use only the low half of each source and return zero in the upper half of the result. The available operations are add, subtract, add-with-carry, signed and unsigned minimum and maximum, low-half multiply, conditional select, and bitwise logic in 32-bit and 64-bit forms.

The unit holds a one-bit condition flag. Each opcode has its own rule for the flag. The arithmetic ops write a carry, a borrow or a signed-overflow indication. The logic ops write whether the result is non-zero. Min, max, multiply and select leave the flag as it was. Add-with-carry and select read the flag.

The operation interface is valid/ready on both sides. An operation is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result sits in an output register with `out_valid` set until `out_ready` takes it. `in_ready` falls only while a result is held and `out_ready` is low, so back-pressure costs no bubble when the consumer is ready. The flag is updated when an operation is accepted, so the operation after it sees the new value.

Top module: `scalar_alu`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operation is accepted on an edge where `in_valid && in_ready`. Its result and flag appear on `out_result`/`out_scc` with `out_valid` high after that edge. They stay unchanged while `out_valid && !out_ready`.
- R2: Opcode values on `in_op` are: 0 add-u32, 1 add-i32, 2 sub-u32, 3 sub-i32, 4 add-carry-u32, 5 min-i32, 6 max-i32, 7 min-u32, 8 max-u32, 9 mul-i32, 10 and-32, 11 or-32, 12 xor-32, 13 and-64, 14 and-not-64 (src0 & ~src1), 15 or-64, 16 or-not-64 (src0 | ~src1), 17 xor-64, 18 nand-64, 19 nor-64, 20 select-32, 21 select-64. Values 22 to 31 are illegal.
- R3: Unsigned 32-bit add sets the flag to the carry out of bit 31. Unsigned 32-bit subtract sets the flag to the borrow, which is 1 when src0 < src1 as unsigned values.
- R4: Signed 32-bit add sets the flag when both operand signs match and the result sign differs from src0's sign. Signed subtract sets the flag when the operand signs differ and the result sign differs from src0's sign.
- R5: Add-with-carry returns src0 + src1 + flag. The new flag is the carry of the first sum ORed with the carry of adding the old flag.
- R6: Min/max (signed and unsigned) return the chosen operand. Multiply returns the low 32 bits of the product. None of these ops changes the flag.
- R7: The 32-bit and/or/xor ops set the flag when the 32-bit result is non-zero. Every 32-bit op ignores source bits 63:32 and returns 0 in result bits 63:32.
- R8: The 64-bit logic ops set the flag when any of the 64 result bits is 1.
- R9: Select returns src0 when the flag is 1 and src1 when it is 0, in both widths, and leaves the flag unchanged.
- R10: After reset, `out_valid`, `out_result`, `out_scc` and `out_illegal` are 0. The flag changes only on an accepted operation.
- R11: An accepted illegal opcode produces an output beat with `out_illegal` high. `out_result` and the flag keep their previous values. `out_illegal` is 0 for a legal opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 5 | Opcode |
| in_src0 | input | 64 | First source operand |
| in_src1 | input | 64 | Second source operand |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 64 | Destination value |
| out_scc | output | 1 | Condition flag after the operation |
| out_illegal | output | 1 | The held beat came from an illegal opcode |

## Verification
The bench builds the unit with its default lane width of 32 bits, so the data path is 64 bits. That width puts carry out of bit 31, the signed-overflow boundary at 0x7FFFFFFF/0x80000000 and a non-zero result confined to the upper half within reach of directed vectors. The vector sequence chains the flag from one operation into the next. This exercises add-with-carry with each of its two carry sources, and select with the flag both set and clear. Directed steps then cover illegal opcodes with the flag both set and clear, idle cycles, and a stalled output that refuses a second operation.

// File: rtl/salu_pkg.sv
package salu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_U32  = 5'd0,
    OP_ADD_I32  = 5'd1,
    OP_SUB_U32  = 5'd2,
    OP_SUB_I32  = 5'd3,
    OP_ADDC_U32 = 5'd4,
    OP_MIN_I32  = 5'd5,
    OP_MAX_I32  = 5'd6,
    OP_MIN_U32  = 5'd7,
    OP_MAX_U32  = 5'd8,
    OP_MUL_I32  = 5'd9,
    OP_AND_32   = 5'd10,
    OP_OR_32    = 5'd11,
    OP_XOR_32   = 5'd12,
    OP_AND_64   = 5'd13,
    OP_ANDN_64  = 5'd14,
    OP_OR_64    = 5'd15,
    OP_ORN_64   = 5'd16,
    OP_XOR_64   = 5'd17,
    OP_NAND_64  = 5'd18,
    OP_NOR_64   = 5'd19,
    OP_SEL_32   = 5'd20,
    OP_SEL_64   = 5'd21
  } salu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH,
    CLS_LOGIC,
    CLS_SELECT,
    CLS_BAD
  } salu_cls_e;

  function automatic salu_cls_e op_class(input logic [OP_W-1:0] op);
    if (op <= 5'd9)       return CLS_ARITH;
    else if (op <= 5'd19) return CLS_LOGIC;
    else if (op <= 5'd21) return CLS_SELECT;
    else                  return CLS_BAD;
  endfunction

  function automatic logic op_is_half(input logic [OP_W-1:0] op);
    return (op <= 5'd12) || (op == 5'd20);
  endfunction

  function automatic logic op_keeps_flag(input logic [OP_W-1:0] op);
    return ((op >= 5'd5) && (op <= 5'd9)) || (op == 5'd20) || (op == 5'd21);
  endfunction

endpackage

// File: rtl/salu_arith.sv
module salu_arith
  import salu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            flag_in,
  output logic [W-1:0]    res,
  output logic            flag_out,
  output logic            flag_we
);

  localparam int MSB = W - 1;

  logic [W:0]   sum1;
  logic [W:0]   sum2;
  logic [W:0]   diff;
  logic [W-1:0] prod;
  logic         s_lt;
  logic         u_lt;

  always_comb begin
    sum1 = {1'b0, a} + {1'b0, b};
    sum2 = {1'b0, sum1[MSB:0]} + {{W{1'b0}}, flag_in};
    diff = {1'b0, a} - {1'b0, b};
    prod = a * b;
    s_lt = $signed(a) < $signed(b);
    u_lt = a < b;
  end

  always_comb begin
    res      = '0;
    flag_out = flag_in;
    flag_we  = 1'b0;
    unique case (op)
      OP_ADD_U32: begin
        res      = sum1[MSB:0];
        flag_out = sum1[W];
        flag_we  = 1'b1;
      end
      OP_ADD_I32: begin
        res      = sum1[MSB:0];
        flag_out = (a[MSB] == b[MSB]) && (sum1[MSB] != a[MSB]);
        flag_we  = 1'b1;
      end
      OP_SUB_U32: begin
        res      = diff[MSB:0];
        flag_out = diff[W];
        flag_we  = 1'b1;
      end
      OP_SUB_I32: begin
        res      = diff[MSB:0];
        flag_out = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
        flag_we  = 1'b1;
      end
      OP_ADDC_U32: begin
        res      = sum2[MSB:0];
        flag_out = sum1[W] | sum2[W];
        flag_we  = 1'b1;
      end
      OP_MIN_I32: res = s_lt ? a : b;
      OP_MAX_I32: res = s_lt ? b : a;
      OP_MIN_U32: res = u_lt ? a : b;
      OP_MAX_U32: res = u_lt ? b : a;
      OP_MUL_I32: res = prod;
      default: ;
    endcase
  end

endmodule

// File: rtl/salu_logic.sv
module salu_logic
  import salu_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic [OP_W-1:0]          op,
  input  logic [LANES*LANE_W-1:0]  a,
  input  logic [LANES*LANE_W-1:0]  b,
  output logic [LANES*LANE_W-1:0]  res,
  output logic                     nonzero
);

  logic [LANES-1:0] lane_nz;
  logic             half_op;

  assign half_op = op_is_half(op);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] la, lb, lr;
    logic              keep;
    assign la   = a[g*LANE_W +: LANE_W];
    assign lb   = b[g*LANE_W +: LANE_W];
    assign keep = (g == 0) || !half_op;
    always_comb begin
      unique case (op)
        OP_AND_32, OP_AND_64: lr = la & lb;
        OP_OR_32,  OP_OR_64:  lr = la | lb;
        OP_XOR_32, OP_XOR_64: lr = la ^ lb;
        OP_ANDN_64:           lr = la & ~lb;
        OP_ORN_64:            lr = la | ~lb;
        OP_NAND_64:           lr = ~(la & lb);
        OP_NOR_64:            lr = ~(la | lb);
        default:              lr = '0;
      endcase
    end
    assign res[g*LANE_W +: LANE_W] = keep ? lr : '0;
    assign lane_nz[g]              = keep && (|lr);
  end

  assign nonzero = |lane_nz;

endmodule

// File: rtl/salu_select.sv
module salu_select
  import salu_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 2
) (
  input  logic [OP_W-1:0]          op,
  input  logic                     flag,
  input  logic [LANES*LANE_W-1:0]  a,
  input  logic [LANES*LANE_W-1:0]  b,
  output logic [LANES*LANE_W-1:0]  res
);

  logic wide;
  assign wide = (op == OP_SEL_64);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] pick;
    assign pick = flag ? a[g*LANE_W +: LANE_W] : b[g*LANE_W +: LANE_W];
    assign res[g*LANE_W +: LANE_W] = ((g == 0) || wide) ? pick : '0;
  end

endmodule

// File: rtl/scalar_alu.sv
module scalar_alu
  import salu_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [4:0]             in_op,
  input  logic [2*LANE_W-1:0]    in_src0,
  input  logic [2*LANE_W-1:0]    in_src1,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [2*LANE_W-1:0]    out_result,
  output logic                   out_scc,
  output logic                   out_illegal
);

  localparam int LANES  = 2;
  localparam int DATA_W = LANES * LANE_W;

  logic              accept;
  salu_cls_e         cls;
  logic [LANE_W-1:0] ar_res;
  logic              ar_flag, ar_we;
  logic [DATA_W-1:0] lg_res, sel_res;
  logic              lg_nz;
  logic [DATA_W-1:0] nxt_res;
  logic              nxt_flag, nxt_we, bad_op;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign cls      = op_class(in_op);

  salu_arith #(.W(LANE_W)) u_arith (
    .op(in_op), .a(in_src0[LANE_W-1:0]), .b(in_src1[LANE_W-1:0]),
    .flag_in(out_scc), .res(ar_res), .flag_out(ar_flag), .flag_we(ar_we)
  );

  salu_logic #(.LANE_W(LANE_W), .LANES(LANES)) u_logic (
    .op(in_op), .a(in_src0), .b(in_src1), .res(lg_res), .nonzero(lg_nz)
  );

  salu_select #(.LANE_W(LANE_W), .LANES(LANES)) u_sel (
    .op(in_op), .flag(out_scc), .a(in_src0), .b(in_src1), .res(sel_res)
  );

  always_comb begin
    nxt_res  = out_result;
    nxt_flag = out_scc;
    nxt_we   = 1'b0;
    bad_op   = 1'b0;
    unique case (cls)
      CLS_ARITH: begin
        nxt_res  = {{(DATA_W-LANE_W){1'b0}}, ar_res};
        nxt_flag = ar_flag;
        nxt_we   = ar_we;
      end
      CLS_LOGIC: begin
        nxt_res  = lg_res;
        nxt_flag = lg_nz;
        nxt_we   = 1'b1;
      end
      CLS_SELECT: nxt_res = sel_res;
      default:    bad_op  = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_scc     <= 1'b0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_illegal <= bad_op;
      if (!bad_op) out_result <= nxt_res;
      if (nxt_we)  out_scc    <= nxt_flag;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_scc)); // R1

  AST_IDLE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(out_scc)); // R10

  AST_KEEP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_keeps_flag(in_op) |=> $stable(out_scc)); // R6

  AST_HALF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && op_is_half(in_op) |=> out_result[DATA_W-1:LANE_W] == '0); // R7

  AST_BAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op > 5'd21
    |=> out_illegal && $stable(out_result) && $stable(out_scc)); // R11

  AST_GOOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op <= 5'd21 |=> !out_illegal); // R11

endmodule

// File: tb/tb_scalar_alu.sv
module tb_scalar_alu;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [4:0]  in_op = '0;
  logic [63:0] in_src0 = '0;
  logic [63:0] in_src1 = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic        out_scc;
  logic        out_illegal;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  scalar_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src0(in_src0), .in_src1(in_src1),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_scc(out_scc), .out_illegal(out_illegal)
  );

  // {op, src0, src1, expected result, expected flag}; flag chains from entry to entry
  localparam int NV = 32;
  localparam logic [197:0] VEC [NV] = '{
    {5'd0,  64'hFFFFFFFF, 64'h1, 64'h0, 1'b1},                       // R3 carry
    {5'd4,  64'h5, 64'h6, 64'hC, 1'b0},                              // R5 uses flag
    {5'd0,  64'hFFFFFFFF, 64'hFFFFFFFF, 64'hFFFFFFFE, 1'b1},         // R3
    {5'd4,  64'hFFFFFFFF, 64'h0, 64'h0, 1'b1},                       // R5 second carry
    {5'd4,  64'h80000000, 64'h80000000, 64'h1, 1'b1},                // R5 first carry
    {5'd1,  64'h7FFFFFFF, 64'h1, 64'h80000000, 1'b1},                // R4 overflow
    {5'd1,  64'h7FFFFFFF, 64'hFFFFFFFF, 64'h7FFFFFFE, 1'b0},         // R4 none
    {5'd2,  64'h3, 64'h5, 64'hFFFFFFFE, 1'b1},                       // R3 borrow
    {5'd2,  64'h5, 64'h3, 64'h2, 1'b0},                              // R3
    {5'd3,  64'h80000000, 64'h1, 64'h7FFFFFFF, 1'b1},                // R4 sub overflow
    {5'd5,  64'hFFFFFFFF, 64'h5, 64'hFFFFFFFF, 1'b1},                // R6
    {5'd7,  64'hFFFFFFFF, 64'h5, 64'h5, 1'b1},                       // R6
    {5'd6,  64'hFFFFFFFF, 64'h5, 64'h5, 1'b1},                       // R6
    {5'd8,  64'hFFFFFFFF, 64'h5, 64'hFFFFFFFF, 1'b1},                // R6
    {5'd9,  64'hFFFFFFFF, 64'h3, 64'hFFFFFFFD, 1'b1},                // R6
    {5'd9,  64'h10000, 64'h10000, 64'h0, 1'b1},                      // R6
    {5'd3,  64'h1, 64'h1, 64'h0, 1'b0},                              // R4
    {5'd20, 64'h12340000_0000AAAA, 64'h0000BBBB, 64'hBBBB, 1'b0},    // R9
    {5'd10, 64'hFFFFFFFF_F0F0F0F0, 64'hFFFFFFFF_0F0F0F0F, 64'h0, 1'b0}, // R7
    {5'd11, 64'h0, 64'h100, 64'h100, 1'b1},                          // R7
    {5'd21, 64'h11112222_33334444, 64'h55556666_77778888, 64'h11112222_33334444, 1'b1}, // R9
    {5'd12, 64'h5, 64'h5, 64'h0, 1'b0},                              // R7
    {5'd21, 64'h11112222_33334444, 64'h55556666_77778888, 64'h55556666_77778888, 1'b0}, // R9
    {5'd13, 64'h80000000_00000000, 64'hFFFFFFFF_FFFFFFFF, 64'h80000000_00000000, 1'b1}, // R8
    {5'd14, 64'hFF00, 64'hF00, 64'hF000, 1'b1},                      // R8
    {5'd15, 64'h0, 64'h0, 64'h0, 1'b0},                              // R8
    {5'd16, 64'h0, 64'hFFFFFFFF_00000000, 64'h00000000_FFFFFFFF, 1'b1}, // R8
    {5'd17, 64'h01234567_89ABCDEF, 64'h01234567_89ABCDEF, 64'h0, 1'b0}, // R8
    {5'd18, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b1},              // R8
    {5'd19, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 64'h0, 1'b0},              // R8
    {5'd19, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b1},              // R8
    {5'd18, 64'hFFFFFFFF_FFFFFFFF, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 1'b0}  // R8
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, capture at posedge, sample at following negedge
  task automatic issue(input logic [4:0] op, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src0 = a; in_src1 = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R10 valid", 64'(out_valid), 64'h0);
    chk("R10 result", out_result, 64'h0);
    chk("R10 flag", 64'(out_scc), 64'h0);
    chk("R10 illegal", 64'(out_illegal), 64'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][197:193], VEC[i][192:129], VEC[i][128:65]);
      chk($sformatf("R2 vec%0d result", i), out_result, VEC[i][64:1]);
      chk($sformatf("R2 vec%0d flag", i), 64'(out_scc), 64'(VEC[i][0]));
      chk($sformatf("R11 vec%0d illegal", i), 64'(out_illegal), 64'h0);
    end

    // R11: illegal with flag clear (previous result 0, flag 0)
    issue(5'd25, 64'h1234, 64'h5678);
    chk("R11 illegal flag out", 64'(out_illegal), 64'h1);
    chk("R11 result held", out_result, 64'h0);
    chk("R11 flag held", 64'(out_scc), 64'h0);
    // R11: illegal with flag set
    issue(5'd11, 64'h0, 64'h77);
    issue(5'd31, 64'hFFFF, 64'hFFFF);
    chk("R11 illegal flag out 2", 64'(out_illegal), 64'h1);
    chk("R11 result held 2", out_result, 64'h77);
    chk("R11 flag held 2", 64'(out_scc), 64'h1);

    // R10: idle cycle keeps flag, drops valid
    @(negedge clk);
    chk("R10 idle valid", 64'(out_valid), 64'h0);
    chk("R10 idle flag", 64'(out_scc), 64'h1);

    // R1: back-pressure
    out_ready = 1'b0;
    issue(5'd11, 64'h0, 64'h33);
    chk("R1 valid", 64'(out_valid), 64'h1);
    chk("R1 result", out_result, 64'h33);
    in_valid = 1'b1; in_op = 5'd12; in_src0 = 64'h5; in_src1 = 64'h5;
    chk("R1 ready low", 64'(in_ready), 64'h0);
    @(negedge clk);
    chk("R1 held result", out_result, 64'h33);
    chk("R1 held flag", 64'(out_scc), 64'h1);
    chk("R1 held valid", 64'(out_valid), 64'h1);
    out_ready = 1'b1;
    #1;
    chk("R1 ready high", 64'(in_ready), 64'h1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 after release result", out_result, 64'h0);
    chk("R7 after release flag", 64'(out_scc), 64'h0);
    @(negedge clk);
    chk("R1 drain", 64'(out_valid), 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule